// File: doc/BRIEF.md
# Level/Edge Interrupt Controller

This block gathers up to 32 interrupt request lines into one pending register and drives two processor interrupt lines, a normal one and a critical one. Each line is latched on a rising edge or follows its level, chosen per line. A pending line reaches an output only when it is enabled. A per-line routing mask then sends it to the normal output or to the critical output.

Software reaches the controller through a small register port with address, write enable, write data, read enable and read data. The registers sit at nine consecutive word addresses above a configurable base address. Software can clear pending bits. Level lines that are still asserted come straight back after a clear. Software can also force pending bits from a separate set register. The polarity register is stored and returned on a read, and it has no other effect. The vector register and the vector-configuration register keep their addresses for a separate vector generator.

Top module: `intc_core`

## Requirements
- R1: Input line n drives pending bit (NSRC-1-n), so line 0 is the most significant pending bit.
- R2: A line whose trigger bit is 1 is edge sensitive. A 0-to-1 change of its synchronised input sets its pending bit. A low input leaves the bit unchanged. An input held high sets the bit only once.
- R3: A line whose trigger bit is 0 is level sensitive. Its pending bit is set when the synchronised input rises and cleared when it falls.
- R4: A write to the pending register (base+0) clears every bit written as 1. In the same write, any level-sensitive line whose input is still high keeps or regains its bit.
- R5: A write to the set register (base+1) ORs the written value into the pending register. A read at base+1 returns the pending register.
- R6: The enable (base+2), routing (base+3, 1 = critical), polarity (base+4) and trigger (base+5) registers return the last value written. The masked view (base+6) reads as pending AND enable. Writes to base+6 and to the vector register (base+7) are ignored.
- R7: The normal output is high one cycle after (pending AND enable AND NOT routing) becomes nonzero, and low one cycle after it becomes zero.
- R8: The critical output follows (pending AND enable AND routing) in the same way.
- R9: The vector-configuration register (base+8) stores the written value with bit 1 forced to 0. The vector register reads as zero.
- R10: Reset clears every register and both outputs.
- R11: A read of an address below the base, or at base+9 or above, returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NSRC | Interrupt request lines, asynchronous |
| bus_addr_i | input | AW | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | NSRC | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | NSRC | Read data, valid the cycle after the read strobe |
| irq_norm_o | output | 1 | Normal interrupt, registered |
| irq_crit_o | output | 1 | Critical interrupt, registered |

## Verification
The assertions assume the register port carries at most one access per cycle, with never a read and a write in the same cycle. They also assume each request line holds a new level for longer than the synchroniser depth. The stimulus keeps to both: every access is a single-cycle strobe issued between clock edges, and request lines change only between clock edges and stay put for several cycles before the pending register is read. The edge-hold and level-reassert properties depend on the trigger register staying fixed while a line changes. Because of this, the bench reprograms the trigger register only while all request lines are low.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [3:0] {
    OFF_STAT   = 4'd0,
    OFF_SET    = 4'd1,
    OFF_EN     = 4'd2,
    OFF_CRIT   = 4'd3,
    OFF_POL    = 4'd4,
    OFF_TRIG   = 4'd5,
    OFF_MASKED = 4'd6,
    OFF_VEC    = 4'd7,
    OFF_VCFG   = 4'd8
  } reg_off_e;

  localparam int unsigned NUM_OFFS = 9;
  localparam int unsigned OFF_W    = 4;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/intc_status.sv
module intc_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] trig_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] held;
  logic [W-1:0] stat_q;

  assign held = lvl_i & ~trig_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = stat_q[b];
      if (clr_we_i) nxt = (nxt & ~wdata_i[b]) | held[b];
      if (set_we_i) nxt = nxt | wdata_i[b];
      if (rise_i[b]) nxt = 1'b1;
      if (fall_i[b] && !trig_i[b]) nxt = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) stat_q[b] <= 1'b0;
      else     stat_q[b] <= nxt;
    end
  end

  assign stat_o = stat_q;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_we_i)) |-> ((($past(stat_q) & $past(trig_i)) & ~stat_q) == '0)); // R2

  AST_LEVEL_REASSERT: assert property (@(posedge clk) disable iff (rst)
    $past(clr_we_i) |-> ((stat_q & $past(held)) == $past(held))); // R4
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned   NSRC        = 32,
  parameter int unsigned   AW          = 10,
  parameter logic [AW-1:0] BASE        = 'h0C0,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_we_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  input  logic            bus_re_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic            irq_norm_o,
  output logic            irq_crit_o
);
  localparam int unsigned DW = NSRC;
  localparam logic [DW-1:0] VCFG_KEEP = ~(DW'(2));

  logic [NSRC-1:0] irq_mapped;
  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign irq_mapped[NSRC-1-n] = irq_i[n];
  end

  logic [AW-1:0]    rel;
  logic             hit;
  logic [OFF_W-1:0] off;
  assign rel = bus_addr_i - BASE;
  assign hit = (bus_addr_i >= BASE) && (rel < AW'(NUM_OFFS));
  assign off = rel[OFF_W-1:0];

  logic wr_hit;
  assign wr_hit = bus_we_i && hit;

  logic [DW-1:0] en_q, crit_q, pol_q, trig_q, vcfg_q;
  logic [DW-1:0] stat;
  logic [NSRC-1:0] lvl, rise, fall;

  intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(irq_mapped),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  intc_status #(.W(NSRC)) status_i (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .trig_i(trig_q),
    .clr_we_i(wr_hit && off == OFF_STAT),
    .set_we_i(wr_hit && off == OFF_SET),
    .wdata_i(bus_wdata_i),
    .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
    end else if (wr_hit) begin
      case (off)
        OFF_EN:   en_q   <= bus_wdata_i;
        OFF_CRIT: crit_q <= bus_wdata_i;
        OFF_POL:  pol_q  <= bus_wdata_i;
        OFF_TRIG: trig_q <= bus_wdata_i;
        OFF_VCFG: vcfg_q <= bus_wdata_i & VCFG_KEEP;
        default: ;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_STAT, OFF_SET: rd_mux = stat;
        OFF_EN:            rd_mux = en_q;
        OFF_CRIT:          rd_mux = crit_q;
        OFF_POL:           rd_mux = pol_q;
        OFF_TRIG:          rd_mux = trig_q;
        OFF_MASKED:        rd_mux = stat & en_q;
        OFF_VCFG:          rd_mux = vcfg_q;
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      irq_norm_o  <= 1'b0;
      irq_crit_o  <= 1'b0;
    end else begin
      if (bus_re_i) bus_rdata_o <= rd_mux;
      irq_norm_o <= |(stat & en_q & ~crit_q);
      irq_crit_o <= |(stat & en_q & crit_q);
    end
  end

  AST_NORM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_norm_o |-> ($past(en_q & ~crit_q) != '0)); // R7

  AST_CRIT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (rst)
    irq_crit_o |-> ($past(en_q & crit_q) != '0)); // R8

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (rst)
    $past(bus_re_i && hit && off == OFF_MASKED) |-> ((bus_rdata_o & ~$past(en_q)) == '0)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_norm_o && !irq_crit_o && bus_rdata_o == '0)); // R10
endmodule

// File: tb/intc_core_tb.sv
module intc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        norm, crit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_core dut_i (
    .clk(clk), .rst(rst), .irq_i(irq), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_re_i(re), .bus_rdata_o(rdata),
    .irq_norm_o(norm), .irq_crit_o(crit)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] x;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'h0C2, 32'hA5A5_0F0F, 32'h0},
    '{1'b0, 10'h0C2, 32'h0, 32'hA5A5_0F0F},
    '{1'b1, 10'h0C3, 32'h0000_FFFF, 32'h0},
    '{1'b0, 10'h0C3, 32'h0, 32'h0000_FFFF},
    '{1'b1, 10'h0C4, 32'h1234_5678, 32'h0},
    '{1'b0, 10'h0C4, 32'h0, 32'h1234_5678},
    '{1'b1, 10'h0C5, 32'hFFFF_0000, 32'h0},
    '{1'b0, 10'h0C5, 32'h0, 32'hFFFF_0000},
    '{1'b1, 10'h0C6, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 10'h0C6, 32'h0, 32'h0},
    '{1'b1, 10'h0C7, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 10'h0C7, 32'h0, 32'h0},
    '{1'b1, 10'h0C8, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 10'h0C8, 32'h0, 32'hFFFF_FFFD},
    '{1'b0, 10'h0C9, 32'h0, 32'h0},
    '{1'b0, 10'h0BF, 32'h0, 32'h0},
    '{1'b1, 10'h0C9, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 10'h0C9, 32'h0, 32'h0},
    '{1'b0, 10'h0C0, 32'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [9:0] a);
    if (a < 10'h0C0 || a > 10'h0C8) return "R11";
    if (a >= 10'h0C7) return "R9";
    return "R6";
  endfunction

  initial begin
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].a, v);
        chk(tag_of(VECS[i].a), v, VECS[i].x);
      end
    end

    // R10: reset clears every register and output
    do_reset();
    for (int o = 0; o < 9; o++) begin
      rd(10'h0C0 + 10'(o), v);
      chk("R10 reg", v, 32'h0);
    end
    chk("R10 norm", {31'b0, norm}, 32'h0);
    chk("R10 crit", {31'b0, crit}, 32'h0);

    // R1, R2: edge mode
    wr(10'h0C5, 32'hFFFF_FFFF);
    irq[0] = 1'b1; settle();
    rd(10'h0C0, v); chk("R1 line0 to msb", v, 32'h8000_0000);
    wr(10'h0C0, 32'h8000_0000); settle();
    rd(10'h0C0, v); chk("R2 held high sets once", v, 32'h0);
    irq[0] = 1'b0; settle();
    irq[3] = 1'b1; repeat (3) @(negedge clk); irq[3] = 1'b0; settle();
    rd(10'h0C0, v); chk("R2 low keeps bit", v, 32'h1000_0000);

    // R3, R4: level mode
    wr(10'h0C5, 32'h0);
    wr(10'h0C0, 32'hFFFF_FFFF);
    irq[31] = 1'b1; settle();
    rd(10'h0C0, v); chk("R3 level rise", v, 32'h0000_0001);
    wr(10'h0C0, 32'hFFFF_FFFF); settle();
    rd(10'h0C0, v); chk("R4 level reasserts", v, 32'h0000_0001);
    irq[31] = 1'b0; settle();
    rd(10'h0C0, v); chk("R3 level fall", v, 32'h0);

    // R5: set register
    wr(10'h0C1, 32'h00F0_000F); settle();
    rd(10'h0C0, v); chk("R5 set into status", v, 32'h00F0_000F);
    rd(10'h0C1, v); chk("R5 set reads status", v, 32'h00F0_000F);

    // R6 masked, R7, R8 outputs
    wr(10'h0C2, 32'h0000_000F);
    wr(10'h0C3, 32'h0000_0003);
    rd(10'h0C6, v); chk("R6 masked", v, 32'h0000_000F);
    settle();
    chk("R7 norm high", {31'b0, norm}, 32'h1);
    chk("R8 crit high", {31'b0, crit}, 32'h1);
    wr(10'h0C0, 32'h0000_000C); settle();
    chk("R7 norm low", {31'b0, norm}, 32'h0);
    chk("R8 crit stays", {31'b0, crit}, 32'h1);
    wr(10'h0C0, 32'h0000_0003); settle();
    chk("R8 crit low", {31'b0, crit}, 32'h0);
    wr(10'h0C1, 32'h0000_0004); settle();
    chk("R7 norm from set", {31'b0, norm}, 32'h1);
    wr(10'h0C2, 32'h0); settle();
    chk("R7 disabled", {31'b0, norm}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule